// File: doc/BRIEF.md
# Indirect Configuration Port Translator

This block sits on a host I/O bus and turns two well-known port addresses into a path for configuration access. Software first loads a 32-bit address register with an enable flag and the location of one register: bus, device, function and byte offset. A later access to the 32-bit data port is then sent as a single configuration request to that function's 256-byte space. The target is named only by its bus, device and function numbers, never by a memory address.

The data-port access stalls the I/O bus until the configuration response returns. Only one request is ever outstanding. A function that does not exist answers with all ones. When the enable flag is clear, data-port accesses complete at once and touch nothing. All other I/O addresses are left for other decoders.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address register is decoded at dword address 0xCF8. Writes update only the byte lanes whose byte enable is set. The stored fields are enable in bit 31, bus in bits 23:16, device in bits 15:11, function in bits 10:8 and offset in bits 7:0. A read returns the stored value with bits 30:24 read as zero.
- R2: A write to the address register issues no configuration request.
- R3: With enable set, an access to the data port at dword 0xCFC issues one request. The request carries the stored bus, device and function, the dword index offset[7:2], the direction, the byte enables and the write data.
- R4: With enable clear, a data-port access completes in the same cycle with no request. A read returns 0xFFFFFFFF and a write is dropped.
- R5: A forwarded access holds io_ready low until the response cycle. In that cycle io_ready is high and a read returns the response data.
- R6: Only one request is outstanding at a time. Its fields stay stable until the response arrives.
- R7: A response flagged as an absent function makes a read return 0xFFFFFFFF.
- R8: Accesses outside 0xCF8–0xCFF are not claimed. They get no ready and change no state.
- R9: Offset bits 1:0 do not affect dword selection. A byte access within 0xCFC–0xCFF reaches only the lanes chosen by its byte enables.
- R10: After reset the address register reads zero and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O access present, held until ready |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O byte address |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid with io_ready |
| io_ready | output | 1 | Access completes this cycle |
| io_claim | output | 1 | Address falls in this block's window |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_write | output | 1 | Request direction |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dw | output | 6 | Dword index in the 256-byte space |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Write data of the request |
| cfg_rsp_valid | input | 1 | Response for the pending request |
| cfg_rsp_rdata | input | 32 | Response read data |
| cfg_rsp_absent | input | 1 | Target function does not exist |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O address and the two standard port addresses. This places the full decode window, and an unrelated low port, on one short address bus. The bench's responder models a single present function at bus 0, device 3, function 0, answering after a fixed latency. Every other location answers as absent, so stalled reads, lane-merged writes, absent-function reads and enable-off accesses all occur on the same data port.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'hCFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_ready,
  output logic             io_claim,
  output logic             cfg_req_valid,
  output logic             cfg_req_write,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_fn,
  output logic [5:0]       cfg_dw,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_rsp_valid,
  input  logic [31:0]      cfg_rsp_rdata,
  input  logic             cfg_rsp_absent
);
  localparam logic [31:0] ONES = '1;

  logic        en_q;
  logic [7:0]  bus_q, off_q;
  logic [4:0]  dev_q;
  logic [2:0]  fn_q;
  logic        busy, req_we;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;

  wire hit_addr = io_req && (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
  wire hit_data = io_req && (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
  wire start    = hit_data && en_q && !busy;
  wire done     = busy && cfg_rsp_valid;
  wire [31:0] addr_rd = {en_q, 7'b0, bus_q, dev_q, fn_q, off_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      bus_q <= '0;
      dev_q <= '0;
      fn_q  <= '0;
      off_q <= '0;
    end else if (hit_addr && io_we && !busy) begin
      if (io_be[0]) off_q <= io_wdata[7:0];
      if (io_be[1]) {dev_q, fn_q} <= io_wdata[15:8];
      if (io_be[2]) bus_q <= io_wdata[23:16];
      if (io_be[3]) en_q <= io_wdata[31];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      req_we    <= 1'b0;
      req_be    <= '0;
      req_wdata <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      req_we    <= io_we;
      req_be    <= io_be;
      req_wdata <= io_wdata;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  assign io_claim = hit_addr || hit_data;
  assign io_ready = done || (!busy && (hit_addr || (hit_data && !en_q)));

  always_comb begin
    io_rdata = '0;
    if (done && !req_we)
      io_rdata = cfg_rsp_absent ? ONES : cfg_rsp_rdata;
    else if (!busy && hit_addr && !io_we)
      io_rdata = addr_rd;
    else if (!busy && hit_data && !en_q && !io_we)
      io_rdata = ONES;
  end

  assign cfg_req_valid = busy;
  assign cfg_req_write = req_we;
  assign cfg_bus       = bus_q;
  assign cfg_dev       = dev_q;
  assign cfg_fn        = fn_q;
  assign cfg_dw        = off_q[7:2];
  assign cfg_be        = req_be;
  assign cfg_wdata     = req_wdata;
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'hCFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req,
  input logic             io_addr_hit_unused,
  input logic [IO_AW-1:0] io_addr,
  input logic [31:0]      io_rdata,
  input logic             io_ready,
  input logic             io_claim,
  input logic             cfg_req_valid,
  input logic             cfg_req_write,
  input logic [7:0]       cfg_bus,
  input logic [4:0]       cfg_dev,
  input logic [2:0]       cfg_fn,
  input logic [5:0]       cfg_dw,
  input logic [31:0]      cfg_wdata,
  input logic             cfg_rsp_valid,
  input logic             cfg_rsp_absent
);
  wire on_data = io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2];
  wire in_win  = on_data || (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);

  a_r2_req_from_data_port: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) |-> $past(io_req && on_data));

  a_r5_stall_until_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_rsp_valid) |-> !io_ready);

  a_r6_req_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_rsp_valid) |=> (cfg_req_valid && $stable(cfg_bus) &&
      $stable(cfg_dev) && $stable(cfg_fn) && $stable(cfg_dw) &&
      $stable(cfg_wdata) && $stable(cfg_req_write)));

  a_r7_absent_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_rsp_valid && cfg_rsp_absent && !cfg_req_write)
      |-> (io_ready && io_rdata == 32'hFFFF_FFFF));

  a_r8_outside_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !in_win) |-> (!io_claim && !io_ready));

  wire unused_ok = io_addr_hit_unused;
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
  .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr_hit_unused(1'b0),
  .io_addr(io_addr), .io_rdata(io_rdata), .io_ready(io_ready),
  .io_claim(io_claim), .cfg_req_valid(cfg_req_valid),
  .cfg_req_write(cfg_req_write), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
  .cfg_fn(cfg_fn), .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata),
  .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_absent(cfg_rsp_absent)
);

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int NV = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [3:0] io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic io_ready, io_claim;
  logic cfg_req_valid, cfg_req_write;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [5:0] cfg_dw;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata;
  logic cfg_rsp_valid, cfg_rsp_absent;
  logic [31:0] cfg_rsp_rdata;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_bridge uut (.*);

  // responder: one present function at bus 0, device 3, function 0
  logic [31:0] mem [64];
  int cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      cfg_rsp_valid <= 1'b0; cfg_rsp_absent <= 1'b0; cfg_rsp_rdata <= '0; cnt <= 0;
    end else if (cfg_rsp_valid) begin
      cfg_rsp_valid <= 1'b0; cnt <= 0;
    end else if (cfg_req_valid) begin
      if (cnt == LAT-1) begin
        automatic bit present = (cfg_bus == 0) && (cfg_dev == 3) && (cfg_fn == 0);
        cfg_rsp_valid  <= 1'b1;
        cfg_rsp_absent <= !present;
        cfg_rsp_rdata  <= present ? mem[cfg_dw] : 32'h0BAD_0BAD;
        if (present && cfg_req_write)
          for (int b = 0; b < 4; b++)
            if (cfg_be[b]) mem[cfg_dw][8*b +: 8] <= cfg_wdata[8*b +: 8];
      end else cnt <= cnt + 1;
    end
  end

  // request monitor
  int req_count = 0;
  logic prev_v = 0;
  logic [7:0] m_bus; logic [4:0] m_dev; logic [2:0] m_fn; logic [5:0] m_dw;
  logic [3:0] m_be; logic m_we;
  always @(posedge clk) begin
    prev_v <= cfg_req_valid;
    if (rst_n && cfg_req_valid && !prev_v) begin
      req_count <= req_count + 1;
      m_bus <= cfg_bus; m_dev <= cfg_dev; m_fn <= cfg_fn; m_dw <= cfg_dw;
      m_be <= cfg_be; m_we <= cfg_req_write;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic io_access(input logic we, input logic [15:0] a, input logic [3:0] be,
                           input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_be = be; io_wdata = wd;
    waits = 0;
    #1;
    while (!io_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = io_rdata;
    @(posedge clk);
    @(negedge clk);
    io_req = 0; io_we = 0;
  endtask

  // {chk, we, addr, be, wdata, expected}
  typedef logic [85:0] vec_t;
  localparam vec_t VECS [NV] = '{
    {1'b0, 1'b1, 16'hCF8, 4'hF, 32'h8000_1808, 32'h0},
    {1'b0, 1'b1, 16'hCFC, 4'hF, 32'h1122_3344, 32'h0},
    {1'b1, 1'b0, 16'hCFC, 4'hF, 32'h0, 32'h1122_3344},      // R3 R5
    {1'b0, 1'b1, 16'hCF8, 4'hF, 32'h7F00_1810, 32'h0},
    {1'b1, 1'b0, 16'hCF8, 4'hF, 32'h0, 32'h0000_1810},      // R1 reserved zero
    {1'b1, 1'b0, 16'hCFC, 4'hF, 32'h0, 32'hFFFF_FFFF},      // R4 read ones
    {1'b0, 1'b1, 16'hCFC, 4'hF, 32'hAAAA_AAAA, 32'h0},      // R4 dropped
    {1'b0, 1'b1, 16'hCF8, 4'hF, 32'h8000_1810, 32'h0},
    {1'b1, 1'b0, 16'hCFC, 4'hF, 32'h0, 32'h0},              // R4 write had no effect
    {1'b0, 1'b1, 16'hCF8, 4'hF, 32'h8000_1809, 32'h0},
    {1'b0, 1'b1, 16'hCFD, 4'h2, 32'h0000_5500, 32'h0},      // R9 byte lane 1
    {1'b1, 1'b0, 16'hCFC, 4'hF, 32'h0, 32'h1122_5544},      // R9
    {1'b0, 1'b1, 16'hCF8, 4'hF, 32'h8001_1808, 32'h0},
    {1'b1, 1'b0, 16'hCFC, 4'hF, 32'h0, 32'hFFFF_FFFF},      // R7 bus 1
    {1'b0, 1'b1, 16'hCF8, 4'hF, 32'h8000_2008, 32'h0},
    {1'b1, 1'b0, 16'hCFC, 4'hF, 32'h0, 32'hFFFF_FFFF},      // R7 device 4
    {1'b0, 1'b1, 16'hCF8, 4'h8, 32'h0000_0000, 32'h0},
    {1'b1, 1'b0, 16'hCF8, 4'hF, 32'h0, 32'h0000_2008},      // R1 lane 3 only
    {1'b0, 1'b1, 16'hCF8, 4'h3, 32'hFFFF_1808, 32'h0},
    {1'b0, 1'b1, 16'hCF8, 4'hC, 32'h8000_0000, 32'h0},
    {1'b1, 1'b0, 16'hCF8, 4'hF, 32'h0, 32'h8000_1808}       // R1 lanes merged
  };

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int waits, rc;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    check("R10 no request after reset", {31'b0, cfg_req_valid}, 32'h0);
    io_access(1'b0, 16'hCF8, 4'hF, 32'h0, rd, waits);
    check("R10 address register reset", rd, 32'h0);

    // R2 address write issues nothing
    rc = req_count;
    io_access(1'b1, 16'hCF8, 4'hF, 32'h8000_1808, rd, waits);
    repeat (4) @(negedge clk);
    check("R2 no request from address write", req_count, rc);

    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      io_access(v[84], v[83:68], v[67:64], v[63:32], rd, waits);
      if (v[85]) check($sformatf("vector %0d", i), rd, v[31:0]);
    end

    // R3 R5 R6 field routing and stall length
    io_access(1'b1, 16'hCF8, 4'hF, 32'h8000_1B2C, rd, waits);
    rc = req_count;
    io_access(1'b1, 16'hCFE, 4'h4, 32'h0077_0000, rd, waits);
    check("R5 stall cycles", waits, LAT + 1);
    check("R6 exactly one request", req_count, rc + 1);
    check("R3 dev/fn", {24'b0, m_dev, m_fn}, {24'b0, 5'd3, 3'd3});
    check("R3 dw/be/we/bus", {13'b0, m_bus, m_dw, m_be, m_we}, {13'b0, 8'd0, 6'h0B, 4'h4, 1'b1});

    // R8 unclaimed address
    rc = req_count;
    @(negedge clk);
    io_req = 1; io_we = 1; io_addr = 16'h0080; io_be = 4'hF; io_wdata = 32'h0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R8 not claimed/ready", {30'b0, io_claim, io_ready}, 32'h0);
      @(negedge clk);
    end
    io_addr = 16'hCF4;
    #1;
    check("R8 neighbour port unclaimed", {30'b0, io_claim, io_ready}, 32'h0);
    @(negedge clk);
    io_req = 0;
    io_access(1'b0, 16'hCF8, 4'hF, 32'h0, rd, waits);
    check("R8 address register unchanged", rd, 32'h8000_1B2C);
    check("R8 no request", req_count, rc);

    summary();
  end
endmodule